// File: doc/BRIEF.md
# Protected System Clock Controller

This block holds two write-protected 8-bit clock control registers and the clock selection and division logic behind them. It runs in the main oscillator clock domain (`clk`). The system clock comes out as `sys_ce_o`, a one-cycle qualifier that marks each system clock edge. When the main clock is the source, the qualifier fires once every N main cycles, where N is a programmable ratio. When the sub clock is the source, it fires once for each rising edge of `sub_clk_i`, after a two-flop synchronizer. Software reaches both registers over a small register port (`addr` 0 selects control register A, `addr` 1 selects control register B). A write lands only while `prot_en` is high.

Control register A fields: bit 7 selects the source (0 main, 1 sub). Bit 6 forces divide-by-8. Bit 5 stops the main oscillator. Bit 4 enables the sub oscillator. Bit 3 is the sub drive-capacity status. Bit 2 gates peripheral clocks in wait mode. Bit 0 is reserved.

Control register B fields: bits 7:6 hold the divider ratio field. Bit 5 is the main drive-capacity status. Bit 1 is reserved. Bit 0 requests stop mode.

Several rules govern changes to these fields:
- A source switch is checked against oscillator state. A refused switch keeps the old select bit and raises a sticky error flag.
- Ratio and source changes are applied only at the end of a system-clock period.
- A wake-up pulse ends stop mode. A settle count must then elapse before the clock runs again.

Top module: `sysclk_ctrl`

## Requirements
- R1: After reset, register A reads 0x48 and register B reads 0x20. The source is the main clock, the ratio is divide-by-8 and the error flag is clear.
- R2: A write with `prot_en` low changes neither register. A write with `prot_en` high updates the register chosen by `addr`, and the result is visible on `rdata` from the next cycle.
- R3: Register A bit 0 and register B bit 1 always read 0, whatever is written to them.
- R4: With the main clock as source and register A bit 6 set, `sys_ce_o` pulses every 8 main cycles, whatever the value of register B bits 7:6. With bit 6 clear, B[7:6] values 00, 01, 10 and 11 give periods of 1, 2, 4 and 16 cycles.
- R5: A new ratio is applied only when the current period ends. The divider counter then restarts, so the first complete period after the change has the new length.
- R6: Register A bit 7 selects the source (0 main, 1 sub). The active source (`src_o`) changes only at the end of a period of the old source. With the sub clock active, `sys_ce_o` pulses once per `sub_clk_i` rising edge.
- R7: A write that moves A bit 7 from 0 to 1 is refused unless A bit 4 is already 1 and the written bit 4 is also 1. A refused write still stores all other bits, keeps bit 7, and sets `sel_err_o`, which stays set until reset.
- R8: A write that moves A bit 7 from 1 to 0 is refused unless A bit 5 is currently 0 and the written bit 5 is 0. A refusal is handled as in R7.
- R9: A write that sets B bit 0 while it is clear enters stop mode and forces A bit 3 to 1. If A bit 7 was 0, it also forces A bit 6 and B bit 5 to 1. If A bit 7 was 1, those two bits keep their values.
- R10: While B bit 0 is 1, `sys_ce_o` stays low, `stop_o` and `main_stop_o` are high, and `sub_en_o` is low.
- R11: A `wake_i` pulse during stop mode clears B bit 0. `stop_o` stays high and no pulse appears for SETTLE cycles. The divider then restarts from zero, so a divide-by-8 clock gives its first pulse SETTLE+8 cycles after the wake edge.
- R12: `main_stop_o` follows A bit 5 and, when set, halts main-clock pulses without affecting a running sub clock. `sub_en_o` follows A bit 4. `periph_gate_o` is `wait_i` AND A bit 2. `main_drv_o` and `sub_drv_o` show B bit 5 and A bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 1 | Register select: 0 register A, 1 register B |
| wdata | input | 8 | Write data |
| we | input | 1 | Write strobe |
| prot_en | input | 1 | Write protection key; writes are ignored while low |
| rdata | output | 8 | Read data of the selected register |
| sub_clk_i | input | 1 | Sub oscillator clock, sampled in the `clk` domain |
| wake_i | input | 1 | Wake-up request that ends stop mode |
| wait_i | input | 1 | Wait mode is active |
| sys_ce_o | output | 1 | System clock qualifier, one cycle per system clock period |
| src_o | output | 1 | Active clock source: 0 main, 1 sub |
| main_stop_o | output | 1 | Main oscillator stop request |
| sub_en_o | output | 1 | Sub oscillator enable |
| stop_o | output | 1 | Stop mode or settle period in progress |
| periph_gate_o | output | 1 | Gate peripheral clocks in wait mode |
| main_drv_o | output | 1 | Main oscillator drive-capacity status |
| sub_drv_o | output | 1 | Sub oscillator drive-capacity status |
| sel_err_o | output | 1 | Sticky flag for a refused source switch |

## Verification
The bench builds the block with SETTLE at its default of 16. This keeps every stop and wake-up cycle short enough to run several times, and it makes the first pulse after a divide-by-8 restart land at exactly 24 cycles. The bench drives the sub clock with a 6-cycle period, longer than the synchronizer delay. This puts both clean source switches and a switch whose old-source period ends mid-flight within reach, and it lets a sub-clock run continue while the main oscillator is stopped. A behavioural model compares every output each cycle, so ratio changes made in the middle of a period are checked at the exact cycle they take effect.

// File: rtl/sysclk_ctrl.sv
module sysclk_ctrl #(
  parameter int SETTLE = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       addr,
  input  logic [7:0] wdata,
  input  logic       we,
  input  logic       prot_en,
  output logic [7:0] rdata,
  input  logic       sub_clk_i,
  input  logic       wake_i,
  input  logic       wait_i,
  output logic       sys_ce_o,
  output logic       src_o,
  output logic       main_stop_o,
  output logic       sub_en_o,
  output logic       stop_o,
  output logic       periph_gate_o,
  output logic       main_drv_o,
  output logic       sub_drv_o,
  output logic       sel_err_o
);
  localparam int SW = $clog2(SETTLE + 1);

  logic [7:0]    r0, r1, n0, n1;
  logic [4:0]    div_act, cnt, lim;
  logic [SW-1:0] settle;
  logic [2:0]    sy;
  logic          src_act, err;

  wire wr0      = we & prot_en & ~addr;
  wire wr1      = we & prot_en & addr;
  wire to_sub   = ~r0[7] & wdata[7];
  wire to_main  = r0[7] & ~wdata[7];
  wire bad      = (to_sub & ~(r0[4] & wdata[4])) | (to_main & (r0[5] | wdata[5]));
  wire stopped  = r1[0];
  wire enter    = wr1 & wdata[0] & ~stopped;
  wire leave    = stopped & ~n1[0];

  wire run_ok   = ~stopped & (settle == '0);
  wire main_run = run_ok & ~r0[5];
  wire sub_run  = run_ok & r0[4];
  wire tick_m   = main_run & (cnt == div_act - 5'd1);
  wire tick_s   = sub_run & sy[1] & ~sy[2];
  wire bound    = src_act ? (tick_s | ~sub_run) : (tick_m | ~main_run);

  assign lim = r0[6] ? 5'd8 : (r1[7:6] == 2'd3 ? 5'd16 : 5'd1 << r1[7:6]);

  always_comb begin
    n0 = r0;
    n1 = r1;
    if (wr0) n0 = {bad ? r0[7] : wdata[7], wdata[6:1], 1'b0};
    if (wr1) n1 = {wdata[7:2], 1'b0, wdata[0]};
    if (enter) begin
      n0[3] = 1'b1;
      if (!r0[7]) begin
        n0[6] = 1'b1;
        n1[5] = 1'b1;
      end
    end
    if (stopped && wake_i) n1[0] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r0      <= 8'h48;
      r1      <= 8'h20;
      err     <= 1'b0;
      sy      <= '0;
      settle  <= '0;
      src_act <= 1'b0;
      div_act <= 5'd8;
      cnt     <= '0;
    end else begin
      r0 <= n0;
      r1 <= n1;
      sy <= {sy[1:0], sub_clk_i};
      if (wr0 && bad) err <= 1'b1;
      if (leave) settle <= SW'(SETTLE);
      else if (settle != '0) settle <= settle - 1'b1;
      if (bound) src_act <= r0[7];
      if (tick_m || !main_run) begin
        cnt     <= '0;
        div_act <= lim;
      end else begin
        cnt <= cnt + 5'd1;
      end
    end
  end

  assign rdata         = addr ? r1 : r0;
  assign sys_ce_o      = src_act ? tick_s : tick_m;
  assign src_o         = src_act;
  assign main_stop_o   = r0[5] | stopped;
  assign sub_en_o      = r0[4] & ~stopped;
  assign stop_o        = stopped | (settle != '0);
  assign periph_gate_o = wait_i & r0[2];
  assign main_drv_o    = r1[5];
  assign sub_drv_o     = r0[3];
  assign sel_err_o     = err;
endmodule

module sysclk_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       we,
  input logic       prot_en,
  input logic       addr,
  input logic       wd7,
  input logic       wd5,
  input logic       wd0,
  input logic       wake_i,
  input logic [7:0] r0,
  input logic [7:0] r1,
  input logic       sys_ce_o,
  input logic       src_o,
  input logic       main_stop_o,
  input logic       stop_o,
  input logic       sel_err_o
);
  assert_locked_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !prot_en |=> $stable(r0));
  assert_locked_b_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!prot_en && !wake_i) |=> $stable(r1));
  assert_reserved_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (r0[0] == 1'b0) && (r1[1] == 1'b0));
  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sel_err_o |=> sel_err_o);
  assert_main_guard_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (we && prot_en && !addr && r0[7] && !wd7 && r0[5]) |=> r0[7]);
  assert_stop_force_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (we && prot_en && addr && wd0 && !r1[0] && !r0[7]) |=> (r0[6] && r1[5] && r0[3]));
  assert_stop_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    r1[0] |-> (!sys_ce_o && stop_o && main_stop_o));
  assert_settle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(r1[0]) |-> (stop_o && !sys_ce_o));
  assert_main_halt_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (main_stop_o && !src_o) |-> !sys_ce_o);
  assert_no_wd5_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (we && prot_en && !addr && r0[7] && !wd7 && wd5) |=> r0[7]);
endmodule

bind sysclk_ctrl sysclk_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .we(we), .prot_en(prot_en), .addr(addr),
  .wd7(wdata[7]), .wd5(wdata[5]), .wd0(wdata[0]), .wake_i(wake_i),
  .r0(r0), .r1(r1), .sys_ce_o(sys_ce_o), .src_o(src_o),
  .main_stop_o(main_stop_o), .stop_o(stop_o), .sel_err_o(sel_err_o)
);

// File: tb/test_sysclk_ctrl.sv
`timescale 1ns/1ps
module test_sysclk_ctrl;
  localparam int SETTLE = 16;

  logic clk = 0, rst_n = 0, addr = 0, we = 0, prot_en = 0;
  logic sub_clk_i = 0, wake_i = 0, wait_i = 0;
  logic [7:0] wdata = 0, rdata;
  logic sys_ce_o, src_o, main_stop_o, sub_en_o, stop_o, periph_gate_o;
  logic main_drv_o, sub_drv_o, sel_err_o;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sysclk_ctrl #(.SETTLE(SETTLE)) i_sysclk_ctrl (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .we(we),
    .prot_en(prot_en), .rdata(rdata), .sub_clk_i(sub_clk_i), .wake_i(wake_i),
    .wait_i(wait_i), .sys_ce_o(sys_ce_o), .src_o(src_o),
    .main_stop_o(main_stop_o), .sub_en_o(sub_en_o), .stop_o(stop_o),
    .periph_gate_o(periph_gate_o), .main_drv_o(main_drv_o),
    .sub_drv_o(sub_drv_o), .sel_err_o(sel_err_o)
  );

  // behavioural reference model
  logic [7:0] m0 = 8'h48, m1 = 8'h20;
  int  mdiv = 8, mcnt = 0, mset = 0;
  bit  msrc = 0, merr = 0;
  bit  hist[$] = '{0, 0, 0};

  function automatic int ratio(logic [7:0] a, logic [7:0] b);
    if (a[6]) return 8;
    case (b[7:6])
      2'd0: return 1;
      2'd1: return 2;
      2'd2: return 4;
      default: return 16;
    endcase
  endfunction

  function automatic bit exp_ce();
    bit ok = !m1[0] && mset == 0;
    if (msrc) return ok && m0[4] && hist[1] && !hist[0];
    return ok && !m0[5] && (mcnt == mdiv - 1);
  endfunction

  always @(posedge clk) begin
    bit ok, rm, rs, tm, ts;
    logic [7:0] o0, o1;
    if (!rst_n) begin
      m0 = 8'h48; m1 = 8'h20; mdiv = 8; mcnt = 0; mset = 0;
      msrc = 0; merr = 0; hist = '{0, 0, 0};
    end else begin
      ok = !m1[0] && mset == 0;
      rm = ok && !m0[5];
      rs = ok && m0[4];
      tm = rm && (mcnt == mdiv - 1);
      ts = rs && hist[1] && !hist[0];
      if (msrc ? (ts || !rs) : (tm || !rm)) msrc = m0[7];
      if (tm || !rm) begin mcnt = 0; mdiv = ratio(m0, m1); end
      else mcnt++;
      if (mset > 0) mset--;
      o0 = m0; o1 = m1;
      if (we && prot_en && !addr) begin
        ok = 1;
        if (!o0[7] && wdata[7] && !(o0[4] && wdata[4])) ok = 0;
        if (o0[7] && !wdata[7] && (o0[5] || wdata[5])) ok = 0;
        m0 = wdata & 8'hFE;
        if (!ok) begin m0[7] = o0[7]; merr = 1; end
      end
      if (we && prot_en && addr) begin
        m1 = wdata & 8'hFD;
        if (!o1[0] && wdata[0]) begin
          m0[3] = 1;
          if (!o0[7]) begin m0[6] = 1; m1[5] = 1; end
        end
      end
      if (o1[0] && wake_i) m1[0] = 0;
      if (o1[0] && !m1[0]) mset = SETTLE;
      hist.push_back(sub_clk_i);
      void'(hist.pop_front());
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  initial begin
    @(posedge rst_n);
    forever begin
      @(posedge clk);
      #2;
      chk("R2 rdata", rdata, addr ? m1 : m0);
      chk("R4 R5 R6 sys_ce", sys_ce_o, exp_ce());
      chk("R6 src", src_o, msrc);
      chk("R12 main_stop", main_stop_o, m0[5] | m1[0]);
      chk("R12 sub_en", sub_en_o, m0[4] & !m1[0]);
      chk("R11 stop", stop_o, m1[0] || mset != 0);
      chk("R12 periph_gate", periph_gate_o, wait_i & m0[2]);
      chk("R9 main_drv", main_drv_o, m1[5]);
      chk("R9 sub_drv", sub_drv_o, m0[3]);
      chk("R7 sel_err", sel_err_o, merr);
    end
  end

  initial begin
    forever begin
      repeat (3) @(negedge clk);
      sub_clk_i = ~sub_clk_i;
    end
  end

  task automatic wr(input logic a, input logic [7:0] d, input logic key);
    @(negedge clk);
    addr = a; wdata = d; we = 1; prot_en = key;
    @(negedge clk);
    we = 0; prot_en = 0;
  endtask

  task automatic rd(input logic a, input int exp, input string tag);
    @(negedge clk);
    addr = a;
    #1;
    chk(tag, rdata, exp);
  endtask

  task automatic wait_ce(output int n);
    n = 0;
    do begin
      @(posedge clk);
      #2;
      n++;
    end while (!sys_ce_o && n < 200);
  endtask

  task automatic period(input int exp, input string tag);
    int n;
    wait_ce(n);
    wait_ce(n);
    wait_ce(n);
    chk(tag, n, exp);
  endtask

  task automatic count_ce(input int cycles, output int k);
    k = 0;
    repeat (cycles) begin
      @(posedge clk);
      #2;
      if (sys_ce_o) k++;
    end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(0, 8'h48, "R1 reg A reset");
    rd(1, 8'h20, "R1 reg B reset");
    chk("R1 src reset", src_o, 0);
    chk("R1 err reset", sel_err_o, 0);
    period(8, "R1 R4 divide-by-8 at reset");

    wr(0, 8'h08, 0);
    rd(0, 8'h48, "R2 locked write A");
    wr(1, 8'hC0, 0);
    rd(1, 8'h20, "R2 locked write B");

    wr(1, 8'hC0, 1);
    period(8, "R4 bit6 overrides ratio field");
    wr(0, 8'h09, 1);
    rd(0, 8'h08, "R3 reserved A bit0");
    period(16, "R4 R5 divide-by-16");
    wr(1, 8'h02, 1);
    rd(1, 8'h00, "R3 reserved B bit1");
    period(1, "R4 divide-by-1");
    wr(1, 8'h40, 1);
    period(2, "R4 divide-by-2");
    wr(1, 8'h80, 1);
    period(4, "R4 divide-by-4");
    wr(1, 8'hC0, 1);
    repeat (5) @(negedge clk);
    wr(1, 8'h40, 1);
    period(2, "R5 mid-period change");

    wr(0, 8'h88, 1);
    rd(0, 8'h08, "R7 refused switch keeps select");
    chk("R7 error flag", sel_err_o, 1);
    wr(0, 8'h18, 1);
    wr(0, 8'h98, 1);
    rd(0, 8'h98, "R6 switch to sub accepted");
    period(6, "R6 sub clock period");
    chk("R6 source is sub", src_o, 1);
    chk("R7 flag sticky", sel_err_o, 1);

    wr(0, 8'hB8, 1);
    wr(0, 8'h18, 1);
    rd(0, 8'h98, "R8 refused while main stopped");
    wr(0, 8'h98, 1);
    wr(0, 8'h38, 1);
    rd(0, 8'hB8, "R8 refused when setting main stop");
    wr(0, 8'h98, 1);
    wr(0, 8'h18, 1);
    rd(0, 8'h18, "R8 switch to main accepted");
    period(2, "R6 back on main clock");
    chk("R6 source is main", src_o, 0);

    wr(0, 8'h00, 1);
    wr(1, 8'h01, 1);
    rd(0, 8'h48, "R9 main-mode entry forces A");
    rd(1, 8'h21, "R9 main-mode entry forces B");
    count_ce(30, n);
    chk("R10 no pulses in stop", n, 0);
    chk("R10 stop_o", stop_o, 1);
    chk("R10 sub_en low", sub_en_o, 0);
    @(negedge clk);
    wake_i = 1;
    @(negedge clk);
    wake_i = 0;
    chk("R11 settling", stop_o, 1);
    n = 1;
    while (!sys_ce_o && n < 100) begin
      @(posedge clk);
      #2;
      n++;
    end
    chk("R11 first pulse after wake", n, SETTLE + 8);
    rd(1, 8'h20, "R11 stop bit cleared");

    wr(0, 8'h10, 1);
    wr(0, 8'h90, 1);
    wr(1, 8'h00, 1);
    period(6, "R6 sub before stop");
    wr(1, 8'h01, 1);
    rd(0, 8'h98, "R9 sub-mode entry keeps bit6");
    rd(1, 8'h01, "R9 sub-mode entry keeps B bit5");
    count_ce(20, n);
    chk("R10 no pulses in sub stop", n, 0);
    @(negedge clk);
    wake_i = 1;
    @(negedge clk);
    wake_i = 0;
    period(6, "R11 sub clock after wake");

    wait_i = 1;
    wr(0, 8'h94, 1);
    #1;
    chk("R12 periph gate", periph_gate_o, 1);
    wr(0, 8'hB4, 1);
    #1;
    chk("R12 main stop output", main_stop_o, 1);
    period(6, "R12 sub runs with main stopped");
    wait_i = 0;
    #1;
    chk("R12 gate drops", periph_gate_o, 0);
    repeat (10) @(negedge clk);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule